// File: doc/BRIEF.md
# PLL Feedback Divider Ramp Controller

This controller moves a running PLL to a new feedback multiplier N without a relock. It relies on the PLL's built-in dynamic ramp. A single `start` pulse presents the requested N, the present M and N, and the reference frequency in kHz.

The controller first works out the comparison frequency, which is the reference divided by M with the remainder dropped. From that value it picks the two ramp step coefficients. It then enables slowdown mode, loads the new N and enables the ramp, with one microsecond between each of these steps. While the ramp runs, it polls a synchronized ramp-done input once per microsecond. When the ramp finishes or the poll budget runs out, it clears slowdown mode and the ramp enable together. In the same cycle it pulses `done`, with an error flag if one applies. The ramp inside the PLL is not modelled here; it is seen only through the done input.

The microsecond tick comes from a prescaler of `TICK_DIV` system clocks, restarted on entry to each timed state. The state machine has seven states:
- IDLE goes to FIN when the requested N equals the current N, or to CHECK on any other start.
- CHECK goes to STEP for a supported comparison frequency, or to FIN for an unsupported one.
- STEP always goes to SLOW.
- SLOW goes to LOADN on a tick.
- LOADN goes to RAMP on a tick.
- RAMP goes to FIN on a tick that sees done, or on the tick of the last poll.
- FIN always goes back to IDLE.

Top module: `ndr_ctrl`

## Requirements
- R1: After reset, `step_a`, `step_b`, `n_out`, `slow_en`, `ramp_en`, `busy`, `done`, `err_freq` and `err_tmo` are all 0.
- R2: A start whose `n_req` equals `n_cur` raises `done` in the cycle after the start edge, with both error flags low. `slow_en`, `ramp_en`, `n_out` and the step outputs do not change.
- R3: The step outputs are chosen from q = `ref_khz` / `m_cur`, with the remainder dropped:
  - q of 12000, 12800 or 13000 gives `step_a`=0x2B and `step_b`=0x0B.
  - q of 19200 gives 0x12 and 0x08.
  - q of 38400 gives 0x04 and 0x05.
- R4: Any other q, or `m_cur`=0, ends the operation two cycles after start with `done` and `err_freq`. In that case `slow_en` never rises and `n_out` and the step outputs keep their values.
- R5: The step outputs take their new values one cycle before `slow_en` rises, and they never change while `slow_en` is high.
- R6: `n_out` takes the requested N exactly `TICK_DIV` cycles after `slow_en` rises. `ramp_en` rises exactly `TICK_DIV` cycles after that. `n_out` changes only while `slow_en` is high and `ramp_en` is low.
- R7: The done input passes through two flops and is polled once every `TICK_DIV` cycles while `ramp_en` is high. If a poll sees it, the operation ends with `done` and neither error flag. `ramp_en` is then high for a whole multiple of `TICK_DIV` cycles, and for at most `POLL_MAX` ticks.
- R8: If `POLL_MAX` polls all miss, the operation ends with `done` and `err_tmo` after `ramp_en` has been high for exactly `POLL_MAX`*`TICK_DIV` cycles.
- R9: On every ramp exit, `slow_en` and `ramp_en` fall on the same edge that raises `done`.
- R10: A start while `busy` is high is ignored. The target N captured at the accepted start is the value loaded.
- R11: `ramp_en` is never high while `slow_en` is low.
- R12: `done` is a one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Single-cycle request; ignored while busy |
| n_req | input | N_W | Requested feedback multiplier |
| n_cur | input | N_W | Feedback multiplier now in use |
| m_cur | input | M_W | Reference divider now in use |
| ref_khz | input | REF_W | Reference frequency in kHz |
| ramp_done_raw | input | 1 | Ramp-finished flag from the PLL, asynchronous |
| step_a | output | STEP_W | Ramp step coefficient A |
| step_b | output | STEP_W | Ramp step coefficient B |
| slow_en | output | 1 | Slowdown mode enable |
| ramp_en | output | 1 | Dynamic ramp enable |
| n_out | output | N_W | Feedback multiplier driven to the PLL |
| busy | output | 1 | High from the accepted start through the done cycle |
| done | output | 1 | One-cycle end-of-operation pulse |
| err_freq | output | 1 | With done: unsupported comparison frequency |
| err_tmo | output | 1 | With done: ramp did not finish within the poll budget |

## Verification
The assertions check on every cycle the invariants of the enable ordering:
- the ramp enable sits inside slowdown mode;
- `n_out` moves only between the slowdown and ramp enables;
- the step outputs are frozen while slowdown mode is on;
- `done` is a single pulse that coincides with both enables low;
- the ramp enable never outlasts the poll budget.

Only the bench's scenarios can show the rest:
- which coefficients each comparison frequency selects, including remainder truncation and rejected values;
- the exact microsecond spacing between the steps;
- the no-change shortcut;
- the exact length of a timed-out ramp;
- that a start arriving mid-operation leaves the loaded N alone.

// File: rtl/ndr_pkg.sv
package ndr_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CHECK,
        S_STEP,
        S_SLOW,
        S_LOADN,
        S_RAMP,
        S_FIN
    } ndr_state_e;

    localparam int NUM_RATES = 5;

    // supported comparison frequencies in kHz
    function automatic int unsigned rate_khz(input int idx);
        case (idx)
            0:       return 32'd12000;
            1:       return 32'd12800;
            2:       return 32'd13000;
            3:       return 32'd19200;
            default: return 32'd38400;
        endcase
    endfunction

    function automatic int unsigned rate_step_a(input int idx);
        case (idx)
            0, 1, 2: return 32'h2B;
            3:       return 32'h12;
            default: return 32'h04;
        endcase
    endfunction

    function automatic int unsigned rate_step_b(input int idx);
        case (idx)
            0, 1, 2: return 32'h0B;
            3:       return 32'h08;
            default: return 32'h05;
        endcase
    endfunction

endpackage

// File: rtl/ndr_tick.sv
module ndr_tick #(
    parameter int TICK_DIV = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int CW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr || cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = (cnt_q == LAST);
endmodule

// File: rtl/ndr_sync2.sv
module ndr_sync2 (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic meta_q;
    logic hold_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            hold_q <= 1'b0;
        end else begin
            meta_q <= d;
            hold_q <= meta_q;
        end
    end

    assign q = hold_q;
endmodule

// File: rtl/ndr_step_sel.sv
module ndr_step_sel
    import ndr_pkg::*;
#(
    parameter int REF_W  = 20,
    parameter int M_W    = 8,
    parameter int STEP_W = 8
) (
    input  logic [REF_W-1:0]  ref_khz,
    input  logic [M_W-1:0]    m_div,
    output logic [STEP_W-1:0] sel_a,
    output logic [STEP_W-1:0] sel_b,
    output logic              sel_valid
);
    localparam int PW = REF_W + M_W + 1;

    logic [NUM_RATES-1:0] hit;
    logic [STEP_W-1:0]    a_v [NUM_RATES];
    logic [STEP_W-1:0]    b_v [NUM_RATES];
    logic [PW-1:0]        ref_x;
    logic [PW-1:0]        m_x;

    assign ref_x = PW'(ref_khz);
    assign m_x   = PW'(m_div);

    // truncating ref/m equals F exactly when F*m <= ref < F*m + m
    for (genvar g = 0; g < NUM_RATES; g++) begin : g_rate
        localparam logic [PW-1:0]     RK = PW'(rate_khz(g));
        localparam logic [STEP_W-1:0] RA = STEP_W'(rate_step_a(g));
        localparam logic [STEP_W-1:0] RB = STEP_W'(rate_step_b(g));
        logic [PW-1:0] lo;
        assign lo     = RK * m_x;
        assign hit[g] = (m_div != '0) && (ref_x >= lo) && (ref_x < lo + m_x);
        assign a_v[g] = RA;
        assign b_v[g] = RB;
    end

    always_comb begin
        sel_a = '0;
        sel_b = '0;
        for (int i = 0; i < NUM_RATES; i++) begin
            if (hit[i]) begin
                sel_a = sel_a | a_v[i];
                sel_b = sel_b | b_v[i];
            end
        end
    end

    assign sel_valid = |hit;
endmodule

// File: rtl/ndr_ctrl.sv
module ndr_ctrl
    import ndr_pkg::*;
#(
    parameter int N_W      = 8,
    parameter int M_W      = 8,
    parameter int REF_W    = 20,
    parameter int STEP_W   = 8,
    parameter int TICK_DIV = 100,
    parameter int POLL_MAX = 500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [N_W-1:0]    n_req,
    input  logic [N_W-1:0]    n_cur,
    input  logic [M_W-1:0]    m_cur,
    input  logic [REF_W-1:0]  ref_khz,
    input  logic              ramp_done_raw,
    output logic [STEP_W-1:0] step_a,
    output logic [STEP_W-1:0] step_b,
    output logic              slow_en,
    output logic              ramp_en,
    output logic [N_W-1:0]    n_out,
    output logic              busy,
    output logic              done,
    output logic              err_freq,
    output logic              err_tmo
);
    localparam int PCW = $clog2(POLL_MAX + 1);
    localparam logic [PCW-1:0] POLL_LAST = PCW'(POLL_MAX - 1);

    ndr_state_e state_q, state_d;

    logic              tick;
    logic              tick_clr;
    logic              done_s;
    logic [N_W-1:0]    n_tgt_q;
    logic [M_W-1:0]    m_q;
    logic [REF_W-1:0]  ref_q;
    logic [PCW-1:0]    poll_q;
    logic [STEP_W-1:0] sel_a, sel_b;
    logic              sel_valid;
    logic              last_poll;

    ndr_tick #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tick_clr),
        .tick  (tick)
    );

    ndr_sync2 u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ramp_done_raw),
        .q     (done_s)
    );

    ndr_step_sel #(.REF_W(REF_W), .M_W(M_W), .STEP_W(STEP_W)) u_sel (
        .ref_khz   (ref_q),
        .m_div     (m_q),
        .sel_a     (sel_a),
        .sel_b     (sel_b),
        .sel_valid (sel_valid)
    );

    assign last_poll = (poll_q == POLL_LAST);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start) state_d = (n_req == n_cur) ? S_FIN : S_CHECK;
            S_CHECK: state_d = sel_valid ? S_STEP : S_FIN;
            S_STEP:  state_d = S_SLOW;
            S_SLOW:  if (tick) state_d = S_LOADN;
            S_LOADN: if (tick) state_d = S_RAMP;
            S_RAMP:  if (tick && (done_s || last_poll)) state_d = S_FIN;
            S_FIN:   state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // every timed state starts a full microsecond
    assign tick_clr = (state_d != state_q) &&
                      (state_d inside {S_SLOW, S_LOADN, S_RAMP});

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // output and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_a   <= '0;
            step_b   <= '0;
            slow_en  <= 1'b0;
            ramp_en  <= 1'b0;
            n_out    <= '0;
            done     <= 1'b0;
            err_freq <= 1'b0;
            err_tmo  <= 1'b0;
            n_tgt_q  <= '0;
            m_q      <= '0;
            ref_q    <= '0;
            poll_q   <= '0;
        end else begin
            done     <= 1'b0;
            err_freq <= 1'b0;
            err_tmo  <= 1'b0;
            if (state_q == S_IDLE && start) begin
                n_tgt_q <= n_req;
                m_q     <= m_cur;
                ref_q   <= ref_khz;
            end
            if (state_q == S_CHECK && sel_valid) begin
                step_a <= sel_a;
                step_b <= sel_b;
            end
            if (state_q == S_STEP) begin
                slow_en <= 1'b1;
            end
            if (state_q == S_SLOW && tick) begin
                n_out <= n_tgt_q;
            end
            if (state_q == S_LOADN && tick) begin
                ramp_en <= 1'b1;
                poll_q  <= '0;
            end
            if (state_q == S_RAMP && tick) begin
                poll_q <= poll_q + 1'b1;
            end
            if (state_d == S_FIN && state_q != S_FIN) begin
                done     <= 1'b1;
                slow_en  <= 1'b0;
                ramp_en  <= 1'b0;
                err_freq <= (state_q == S_CHECK);
                err_tmo  <= (state_q == S_RAMP) && !done_s;
            end
        end
    end

    assign busy = (state_q != S_IDLE);
endmodule

// File: rtl/ndr_ctrl_chk.sv
module ndr_ctrl_chk #(
    parameter int N_W      = 8,
    parameter int STEP_W   = 8,
    parameter int TICK_DIV = 100,
    parameter int POLL_MAX = 500
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              slow_en,
    input logic              ramp_en,
    input logic [N_W-1:0]    n_out,
    input logic [STEP_W-1:0] step_a,
    input logic [STEP_W-1:0] step_b,
    input logic              busy,
    input logic              done,
    input logic              err_freq,
    input logic              err_tmo
);
    localparam int LIMIT = POLL_MAX * TICK_DIV;
    localparam int CW    = $clog2(LIMIT + 2);

    logic [CW-1:0] ramp_cyc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ramp_cyc_q <= '0;
        else if (ramp_en) ramp_cyc_q <= ramp_cyc_q + 1'b1;
        else              ramp_cyc_q <= '0;
    end

    // R11
    ramp_needs_slow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ramp_en |-> slow_en);

    // R6
    n_load_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(n_out) |-> (slow_en && !ramp_en));

    // R5
    step_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(step_a) || !$stable(step_b)) |-> !slow_en);

    // R9
    exit_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!slow_en && !ramp_en));

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    tmo_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_tmo |-> (done && !err_freq));

    // R4
    freq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_freq |-> (done && !$past(slow_en)));

    // R8
    poll_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ramp_en |-> (ramp_cyc_q < CW'(LIMIT)));

    // R10
    busy_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));
endmodule

bind ndr_ctrl ndr_ctrl_chk #(
    .N_W      (N_W),
    .STEP_W   (STEP_W),
    .TICK_DIV (TICK_DIV),
    .POLL_MAX (POLL_MAX)
) u_ndr_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .slow_en  (slow_en),
    .ramp_en  (ramp_en),
    .n_out    (n_out),
    .step_a   (step_a),
    .step_b   (step_b),
    .busy     (busy),
    .done     (done),
    .err_freq (err_freq),
    .err_tmo  (err_tmo)
);

// File: tb/tb_ndr_ctrl.sv
module tb_ndr_ctrl;
    localparam int D  = 4;
    localparam int P  = 10;
    localparam int NW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [NW-1:0] n_req = '0;
    logic [NW-1:0] n_cur = '0;
    logic [7:0]    m_cur = '0;
    logic [19:0]   ref_khz = '0;
    logic          ramp_done_raw = 1'b0;
    logic [7:0]    step_a, step_b;
    logic          slow_en, ramp_en, busy, done, err_freq, err_tmo;
    logic [NW-1:0] n_out;

    int total = 0;
    int bad = 0;
    int stub_dly = -1;
    int stub_cnt = 0;

    // observations of one operation
    int r_done_idx, r_slow_rise, r_nchg, r_ramp_rise, r_ramp_len, r_slow_len;
    bit r_freq, r_tmo, r_en_at_done, r_ramp_wo_slow, r_done_after;
    int r_a_before, r_b_before;

    always #5 clk = ~clk;

    ndr_ctrl #(.TICK_DIV(D), .POLL_MAX(P)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .n_req(n_req), .n_cur(n_cur),
        .m_cur(m_cur), .ref_khz(ref_khz), .ramp_done_raw(ramp_done_raw),
        .step_a(step_a), .step_b(step_b), .slow_en(slow_en), .ramp_en(ramp_en),
        .n_out(n_out), .busy(busy), .done(done), .err_freq(err_freq), .err_tmo(err_tmo)
    );

    // PLL ramp stub: done stays low until stub_dly cycles after ramp enable
    always @(negedge clk) begin
        if (!ramp_en) begin
            stub_cnt      <= 0;
            ramp_done_raw <= 1'b0;
        end else begin
            stub_cnt <= stub_cnt + 1;
            if (stub_dly >= 0 && stub_cnt >= stub_dly) ramp_done_raw <= 1'b1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit exp_step(input int ref_v, input int m_v,
                                    output int a, output int b);
        int q;
        a = 0;
        b = 0;
        if (m_v == 0) return 1'b0;
        q = ref_v / m_v;
        case (q)
            12000, 12800, 13000: begin a = 'h2B; b = 'h0B; end
            19200:               begin a = 'h12; b = 'h08; end
            38400:               begin a = 'h04; b = 'h05; end
            default:             return 1'b0;
        endcase
        return 1'b1;
    endfunction

    task automatic run_op(input int nr, input int nc, input int m_v, input int ref_v,
                          input int dly, input int glitch_at);
        int idx;
        logic [NW-1:0] pn;
        logic [7:0] pa, pb;
        bit ps, pr;
        stub_dly = dly;
        r_done_idx = -1; r_slow_rise = -1; r_nchg = -1; r_ramp_rise = -1;
        r_ramp_len = 0; r_slow_len = 0; r_freq = 0; r_tmo = 0;
        r_en_at_done = 0; r_ramp_wo_slow = 0; r_a_before = -1; r_b_before = -1;
        @(negedge clk);
        n_req = NW'(nr); n_cur = NW'(nc); m_cur = 8'(m_v); ref_khz = 20'(ref_v);
        pn = n_out; pa = step_a; pb = step_b; ps = slow_en; pr = ramp_en;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        idx = 1;
        while (idx < 300) begin
            if (slow_en && !ps) begin
                r_slow_rise = idx; r_a_before = pa; r_b_before = pb;
            end
            if (n_out != pn) r_nchg = idx;
            if (ramp_en && !pr) r_ramp_rise = idx;
            if (ramp_en) r_ramp_len++;
            if (slow_en) r_slow_len++;
            if (ramp_en && !slow_en) r_ramp_wo_slow = 1;
            if (done) begin
                r_done_idx = idx; r_freq = err_freq; r_tmo = err_tmo;
                r_en_at_done = slow_en | ramp_en;
                break;
            end
            pn = n_out; pa = step_a; pb = step_b; ps = slow_en; pr = ramp_en;
            if (idx == glitch_at) begin
                n_req = n_req ^ 8'h55;
                start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            idx++;
        end
        start = 1'b0;
        @(negedge clk);
        r_done_after = done;
    endtask

    task automatic check_good(input int nr, input int m_v, input int ref_v, input string tag);
        int ea, eb;
        void'(exp_step(ref_v, m_v, ea, eb));
        chk(r_done_idx > 0 && !r_freq && !r_tmo, {tag, " R7 ends ok"}, {r_freq, r_tmo}, 0);
        chk(step_a == 8'(ea), {tag, " R3 step_a"}, step_a, ea);
        chk(step_b == 8'(eb), {tag, " R3 step_b"}, step_b, eb);
        chk(r_a_before == ea && r_b_before == eb, {tag, " R5 steps before slow"}, r_a_before, ea);
        chk(r_nchg == r_slow_rise + D, {tag, " R6 n load delay"}, r_nchg - r_slow_rise, D);
        chk(n_out == NW'(nr), {tag, " R6 n_out value"}, n_out, nr);
        chk(r_ramp_rise == r_nchg + D, {tag, " R6 ramp delay"}, r_ramp_rise - r_nchg, D);
        chk(r_ramp_len % D == 0 && r_ramp_len > 0 && r_ramp_len <= P * D,
            {tag, " R7 ramp length"}, r_ramp_len, D);
        chk(!r_en_at_done && r_done_idx == r_ramp_rise + r_ramp_len,
            {tag, " R9 enables fall with done"}, r_done_idx, r_ramp_rise + r_ramp_len);
        chk(!r_ramp_wo_slow, {tag, " R11 ramp inside slow"}, r_ramp_wo_slow, 0);
        chk(!r_done_after, {tag, " R12 done pulse"}, r_done_after, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(step_a == 0 && step_b == 0 && n_out == 0, "R1 data outputs", step_a, 0);
        chk(!slow_en && !ramp_en && !busy && !done && !err_freq && !err_tmo,
            "R1 control outputs", {slow_en, ramp_en, busy, done}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2 equal N shortcut
        run_op(20, 20, 1, 38400, 0, -1);
        chk(r_done_idx == 1, "R2 done timing", r_done_idx, 1);
        chk(!r_freq && !r_tmo, "R2 no error", {r_freq, r_tmo}, 0);
        chk(r_slow_rise == -1 && r_ramp_rise == -1 && n_out == 0 && step_a == 0,
            "R2 nothing changed", n_out, 0);

        // R3 R5 R6 R7 R9 sweep over supported frequencies and truncation
        for (int m = 1; m <= 3; m++) begin
            for (int r = 0; r < 5; r++) begin
                for (int k = 0; k < 2; k++) begin
                    int fr, rv, nr;
                    case (r)
                        0: fr = 12000; 1: fr = 12800; 2: fr = 13000;
                        3: fr = 19200; default: fr = 38400;
                    endcase
                    rv = fr * m + ((k == 1) ? (m - 1) : 0);
                    nr = 30 + m * 7 + r * 3 + k;
                    run_op(nr, nr + 1, m, rv, (r * 5 + k * 3) % 20, -1);
                    check_good(nr, m, rv, "sweep");
                end
            end
        end

        // R4 unsupported comparison frequencies
        for (int c = 0; c < 7; c++) begin
            int mv, rv;
            logic [NW-1:0] n0;
            logic [7:0] a0, b0;
            if (c == 6) begin mv = 0; rv = 12000; end
            else begin
                mv = (c % 3) + 1;
                rv = (c < 3) ? (12000 * mv - 1) : (24000 * mv);
            end
            n0 = n_out; a0 = step_a; b0 = step_b;
            run_op(n0 + 5, n0, mv, rv, 0, -1);
            chk(r_done_idx == 2 && r_freq && !r_tmo, "R4 freq error", r_done_idx, 2);
            chk(r_slow_rise == -1 && n_out == n0 && step_a == a0 && step_b == b0,
                "R4 nothing changed", n_out, n0);
        end

        // R8 timeout with a ramp that never finishes
        run_op(90, 10, 1, 38400, -1, -1);
        chk(r_tmo && !r_freq && r_done_idx > 0, "R8 timeout flag", r_tmo, 1);
        chk(r_ramp_len == P * D, "R8 ramp length", r_ramp_len, P * D);
        chk(r_slow_len == (P + 2) * D, "R8 slow length", r_slow_len, (P + 2) * D);
        chk(!r_en_at_done, "R9 timeout exit clears", r_en_at_done, 0);
        chk(!r_done_after, "R12 done pulse after timeout", r_done_after, 0);

        // R10 starts while busy are ignored
        run_op(77, 90, 2, 38400, 3, 2);
        chk(n_out == 77 && !r_tmo && !r_freq, "R10 start in slow wait", n_out, 77);
        run_op(55, 77, 1, 19200, 9, 2 * D + 5);
        chk(n_out == 55 && !r_tmo && !r_freq, "R10 start in ramp", n_out, 55);
        repeat (3) @(negedge clk);
        chk(!busy && n_out == 55, "R10 idle after", busy, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule